// File: doc/BRIEF.md
# Block Cipher Data-Path Sequencer

This block is the control and status layer between a 32-bit word-wide register port and a 128-bit block cipher core. Software writes an input block as four words, and the sequencer assembles them. It then launches the core, either on its own as soon as the block is complete or only when an explicit start command arrives. When the core is done, the sequencer captures the 128-bit result into four readable output words. It tracks which of those words have been read, and it keeps the flags for idle, stall, input ready, output valid, output lost and configuration-update error.

The key arrives as two shares of eight 32-bit words each. The sequencer presents the core with the bitwise XOR of the shares. Words beyond the selected key length are forced to zero. The sequencer also carries out three commands: clear the key and input words, clear the output words, and reseed the core's pseudo-random state. A reseed is deferred while an operation is in flight. The core itself sits behind a one-cycle start pulse and a one-cycle done pulse. The core's result must be valid in the cycle that done is high.

Top module: `cseq_top`

## Requirements
- R1: Input word i (0 to 3) fills bits [32*i+31:32*i] of the block. `in_ready` is low from the moment all four words are present until the operation that consumes them finishes. Input writes made while `in_ready` is low are ignored.
- R2: With `cfg_manual` = 0 (automatic mode), a complete input block in the idle state raises `core_start` for exactly one cycle, with no start command.
- R3: With `cfg_manual` = 1 (manual mode), `core_start` rises only in a cycle where `cmd_start` is high and the input block is complete. In automatic mode `cmd_start` causes no launch.
- R4: When the core reports done, its result goes into the output words and `out_valid` rises. Output word i is bits [32*i+31:32*i] of the result. `out_valid` falls once each of the four words has been read at least once; repeated reads of one word count once.
- R5: In automatic mode, a result that completes while `out_valid` is high is held back. `stall` is high and the output words keep the old result. Once the old result has been fully read, the held result is written and `stall` falls.
- R6: In manual mode, a result written while `out_valid` is high sets `out_lost`. It stays set until the clear-input command.
- R7: The key given to the core is share0 XOR share1, with words beyond the length zeroed. `cfg_klen` 0 keeps words 0 to 3, 1 keeps words 0 to 5, and 2 or 3 keeps all eight.
- R8: A configuration or key-share write while not idle is ignored and sets `upd_err`. It stays set until the clear-input command.
- R9: The clear-input command (`cmd_clr_in`) empties the input block, zeroes both key shares, and clears `out_lost` and `upd_err`.
- R10: The clear-output command (`cmd_clr_out`) zeroes the output words and drops `out_valid`. This releases a pending stall.
- R11: `cmd_reseed` produces one single-cycle `reseed_req` pulse. The pulse is issued only while idle and not launching, so a reseed requested during an operation waits until that operation ends.
- R12: `idle` is high only when no operation is in flight and no stall is pending. Out of reset, `idle` and `in_ready` are high and every other flag is low.
- R13: An illegal sequencer state sets the sticky `fatal` flag and returns to idle. `fatal` stays low in legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_we | input | 1 | Input word write strobe |
| din_idx | input | 2 | Input word index |
| din_word | input | 32 | Input word data |
| dout_re | input | 1 | Output word read strobe (marks the word read) |
| dout_idx | input | 2 | Output word index |
| dout_word | output | 32 | Output word selected by dout_idx |
| key_we | input | 1 | Key share word write strobe |
| key_sel | input | 1 | Share select (0 or 1) |
| key_idx | input | 3 | Key word index |
| key_word | input | 32 | Key word data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_manual | input | 1 | 1 = manual start, 0 = automatic |
| cfg_klen | input | 2 | Key length code |
| cmd_start | input | 1 | Start command (manual mode) |
| cmd_clr_in | input | 1 | Clear key shares and input words |
| cmd_clr_out | input | 1 | Clear output words |
| cmd_reseed | input | 1 | Reseed request command |
| core_start | output | 1 | One-cycle launch pulse to the core |
| core_block | output | 128 | Input block to the core |
| core_key | output | 256 | Working key to the core |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_result | input | 128 | Core result, valid with core_done |
| reseed_req | output | 1 | One-cycle reseed pulse to the core |
| idle | output | 1 | No operation in flight, no stall |
| stall | output | 1 | Result held back behind unread output |
| in_ready | output | 1 | Input block can accept words |
| out_valid | output | 1 | Unread result in the output words |
| out_lost | output | 1 | Unread result was overwritten (sticky) |
| upd_err | output | 1 | Update attempted while busy (sticky) |
| fatal | output | 1 | Illegal sequencer state seen (sticky) |

## Verification
The hardest situation to reach from the ports is a second result finishing while the first is still unread. In automatic mode this must become a stall; in manual mode it must become a lost-output event. The stimulus completes one operation and deliberately leaves its output unread. It then loads and launches a second block and waits past the core latency. The bench peeks the output words with the read strobe low, which proves the old result survives. It then releases the stall once by reading all four words and once by the clear-output command. Writes made while busy are timed one cycle after the launch edge, so that they land while the operation is in flight.

// File: rtl/cseq_pkg.sv
// Package: shared state encoding and key length codes for the cipher
// data-path sequencer. Assumes a two-bit state register, so one code is illegal.
package cseq_pkg;
    localparam int KLEN_W = 2;

    localparam logic [KLEN_W-1:0] KLEN_SHORT = 2'd0;
    localparam logic [KLEN_W-1:0] KLEN_MID   = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BUSY  = 2'b01,
        ST_STALL = 2'b10
    } seq_state_e;
endpackage

// File: rtl/cseq_inbuf.sv
// Input block collector: stores word-wide writes into a block and tracks
// which words are present. Assumes the owner clears it when the block is consumed.
module cseq_inbuf #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    localparam int IDX_W = $clog2(NWORDS),
    localparam int BLK_W = WORD_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr,
    output logic [BLK_W-1:0]  block,
    output logic              full
);
    logic [NWORDS-1:0] have_q;
    logic [BLK_W-1:0]  blk_q;

    assign full  = &have_q;
    assign block = blk_q;

    // Capture words while the block is not yet complete; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= '0;
            blk_q  <= '0;
        end else if (clr) begin
            have_q <= '0;
            blk_q  <= '0;
        end else if (we && !full) begin
            have_q[idx]                <= 1'b1;
            blk_q[idx*WORD_W +: WORD_W] <= wdata;
        end
    end
endmodule

// File: rtl/cseq_keyfold.sv
// Key share store and combiner: holds two shares of word-wide key words and
// presents their XOR, zeroing words above the selected key length.
// Assumes writes are already gated to the idle state by the owner.
module cseq_keyfold
    import cseq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NKW    = 8,
    localparam int KIDX_W = $clog2(NKW),
    localparam int KEY_W  = WORD_W * NKW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [KIDX_W-1:0] idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr,
    input  logic [KLEN_W-1:0] klen,
    output logic [KEY_W-1:0]  key
);
    logic [WORD_W-1:0] sh0_q [NKW];
    logic [WORD_W-1:0] sh1_q [NKW];
    int                lim;

    // Number of live key words for the selected length code.
    always_comb begin
        case (klen)
            KLEN_SHORT: lim = NKW / 2;
            KLEN_MID:   lim = (3 * NKW) / 4;
            default:    lim = NKW;
        endcase
    end

    // Share storage: one word per write, both shares wiped on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NKW; i++) begin
                sh0_q[i] <= '0;
                sh1_q[i] <= '0;
            end
        end else if (we) begin
            if (sel) sh1_q[idx] <= wdata;
            else     sh0_q[idx] <= wdata;
        end
    end

    for (genvar g = 0; g < NKW; g++) begin : g_word
        // Combine the shares of one word, or force zero beyond the length.
        assign key[g*WORD_W +: WORD_W] = (g < lim) ? (sh0_q[g] ^ sh1_q[g]) : '0;
    end
endmodule

// File: rtl/cseq_outbuf.sv
// Output register bank: loads a result, serves word reads, tracks which words
// have been read and flags a load that lands on an unread result.
// Assumes clear has priority over load and load over read marking.
module cseq_outbuf #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    localparam int IDX_W = $clog2(NWORDS),
    localparam int BLK_W = WORD_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLK_W-1:0]  ldata,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    input  logic              clr,
    input  logic              clr_lost,
    output logic [WORD_W-1:0] rdata,
    output logic              valid,
    output logic              lost
);
    logic [WORD_W-1:0] data_q [NWORDS];
    logic [NWORDS-1:0] seen_q;
    logic [NWORDS-1:0] hit;
    logic              valid_q;
    logic              lost_q;

    assign hit   = {{(NWORDS-1){1'b0}}, 1'b1} << ridx;
    assign rdata = data_q[ridx];
    assign valid = valid_q;
    assign lost  = lost_q;

    // Output words, read tracking and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
            seen_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < NWORDS; i++) data_q[i] <= ldata[i*WORD_W +: WORD_W];
            seen_q  <= '0;
            valid_q <= 1'b1;
        end else if (re && valid_q) begin
            seen_q <= seen_q | hit;
            if (&(seen_q | hit)) valid_q <= 1'b0;
        end
    end

    // Sticky overwrite flag, cleared only at the end of a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_lost) lost_q <= 1'b0;
        else if (load && valid_q && !clr) lost_q <= 1'b1;
    end
endmodule

// File: rtl/cseq_fsm.sv
// Sequencer state machine: decides launches, result commits and stalls, and
// schedules deferred reseed pulses. Assumes core_done arrives only while busy.
module cseq_fsm
    import cseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic manual,
    input  logic cmd_start,
    input  logic cmd_reseed,
    input  logic core_done,
    input  logic out_valid,
    output logic core_start,
    output logic consume,
    output logic commit,
    output logic from_hold,
    output logic reseed_req,
    output logic idle,
    output logic stall,
    output logic fatal
);
    seq_state_e st_q, st_d;
    logic       go;
    logic       bad;
    logic       rs_pend_q;
    logic       fatal_q;

    assign go    = full && (manual ? cmd_start : 1'b1);
    assign idle  = (st_q == ST_IDLE);
    assign stall = (st_q == ST_STALL);
    assign fatal = fatal_q;
    assign reseed_req = idle && rs_pend_q && !go;

    // Next-state and per-cycle strobes for launch, consume and commit.
    always_comb begin
        st_d       = st_q;
        core_start = 1'b0;
        consume    = 1'b0;
        commit     = 1'b0;
        from_hold  = 1'b0;
        bad        = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (go) begin
                    core_start = 1'b1;
                    st_d       = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (core_done) begin
                    consume = 1'b1;
                    if (!manual && out_valid) begin
                        st_d = ST_STALL;
                    end else begin
                        commit = 1'b1;
                        st_d   = ST_IDLE;
                    end
                end
            end
            ST_STALL: begin
                if (!out_valid) begin
                    commit    = 1'b1;
                    from_hold = 1'b1;
                    st_d      = ST_IDLE;
                end
            end
            default: begin
                bad  = 1'b1;
                st_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Sticky fatal flag set by the illegal-state branch.
    always_ff @(posedge clk) begin
        if (!rst_n)  fatal_q <= 1'b0;
        else if (bad) fatal_q <= 1'b1;
    end

    // Pending reseed, held until it can be issued while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) rs_pend_q <= 1'b0;
        else        rs_pend_q <= (rs_pend_q && !reseed_req) || cmd_reseed;
    end
endmodule

// File: rtl/cseq_top.sv
// Block cipher data-path sequencer top: joins the input collector, key
// combiner, output bank and state machine; holds configuration, the update
// error flag and the held-back result. Assumes a core with a one-cycle done
// pulse and its result valid in that cycle.
module cseq_top
    import cseq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int KEY_WORDS = 8,
    localparam int IDX_W  = $clog2(BLK_WORDS),
    localparam int KIDX_W = $clog2(KEY_WORDS),
    localparam int BLK_W  = WORD_W * BLK_WORDS,
    localparam int KEY_W  = WORD_W * KEY_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_we,
    input  logic [IDX_W-1:0]  din_idx,
    input  logic [WORD_W-1:0] din_word,
    input  logic              dout_re,
    input  logic [IDX_W-1:0]  dout_idx,
    output logic [WORD_W-1:0] dout_word,
    input  logic              key_we,
    input  logic              key_sel,
    input  logic [KIDX_W-1:0] key_idx,
    input  logic [WORD_W-1:0] key_word,
    input  logic              cfg_we,
    input  logic              cfg_manual,
    input  logic [KLEN_W-1:0] cfg_klen,
    input  logic              cmd_start,
    input  logic              cmd_clr_in,
    input  logic              cmd_clr_out,
    input  logic              cmd_reseed,
    output logic              core_start,
    output logic [BLK_W-1:0]  core_block,
    output logic [KEY_W-1:0]  core_key,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_result,
    output logic              reseed_req,
    output logic              idle,
    output logic              stall,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_lost,
    output logic              upd_err,
    output logic              fatal
);
    logic              manual_q;
    logic [KLEN_W-1:0] klen_q;
    logic              upd_err_q;
    logic [BLK_W-1:0]  hold_q;
    logic              full, consume, commit, from_hold;

    assign in_ready = !full;
    assign upd_err  = upd_err_q;

    // Configuration accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            manual_q <= 1'b0;
            klen_q   <= '0;
        end else if (cfg_we && idle) begin
            manual_q <= cfg_manual;
            klen_q   <= cfg_klen;
        end
    end

    // Sticky flag for configuration or key writes attempted while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_clr_in) upd_err_q <= 1'b0;
        else if ((cfg_we || key_we) && !idle) upd_err_q <= 1'b1;
    end

    // Holding register for a result that must wait behind unread output.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (core_done) hold_q <= core_result;
    end

    cseq_inbuf #(.WORD_W(WORD_W), .NWORDS(BLK_WORDS)) u_inbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (din_we),
        .idx   (din_idx),
        .wdata (din_word),
        .clr   (cmd_clr_in || consume),
        .block (core_block),
        .full  (full)
    );

    cseq_keyfold #(.WORD_W(WORD_W), .NKW(KEY_WORDS)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (key_we && idle),
        .sel   (key_sel),
        .idx   (key_idx),
        .wdata (key_word),
        .clr   (cmd_clr_in),
        .klen  (klen_q),
        .key   (core_key)
    );

    cseq_outbuf #(.WORD_W(WORD_W), .NWORDS(BLK_WORDS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .ldata    (from_hold ? hold_q : core_result),
        .re       (dout_re),
        .ridx     (dout_idx),
        .clr      (cmd_clr_out),
        .clr_lost (cmd_clr_in),
        .rdata    (dout_word),
        .valid    (out_valid),
        .lost     (out_lost)
    );

    cseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .full       (full),
        .manual     (manual_q),
        .cmd_start  (cmd_start),
        .cmd_reseed (cmd_reseed),
        .core_done  (core_done),
        .out_valid  (out_valid),
        .core_start (core_start),
        .consume    (consume),
        .commit     (commit),
        .from_hold  (from_hold),
        .reseed_req (reseed_req),
        .idle       (idle),
        .stall      (stall),
        .fatal      (fatal)
    );
endmodule

// File: rtl/cseq_chk.sv
// Property checker for the sequencer top, attached by bind below.
module cseq_chk (
    input logic clk,
    input logic rst_n,
    input logic core_start,
    input logic in_ready,
    input logic manual,
    input logic cmd_start,
    input logic cmd_clr_in,
    input logic idle,
    input logic stall,
    input logic out_valid,
    input logic out_lost,
    input logic upd_err,
    input logic reseed_req
);
    AST_START_FULL_BUF: assert property (@(posedge clk) disable iff (!rst_n) core_start |-> !in_ready); // R1
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) core_start |=> !core_start); // R2
    AST_MANUAL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n) (core_start && manual) |-> cmd_start); // R3
    AST_STALL_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> out_valid); // R5
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (out_lost && !cmd_clr_in) |=> out_lost); // R6
    AST_UPD_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (upd_err && !cmd_clr_in) |=> upd_err); // R8
    AST_RESEED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) reseed_req |-> (idle && !core_start)); // R11
    AST_STALL_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !idle); // R12
endmodule

bind cseq_top cseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_start (core_start),
    .in_ready   (in_ready),
    .manual     (manual_q),
    .cmd_start  (cmd_start),
    .cmd_clr_in (cmd_clr_in),
    .idle       (idle),
    .stall      (stall),
    .out_valid  (out_valid),
    .out_lost   (out_lost),
    .upd_err    (upd_err),
    .reseed_req (reseed_req)
);

// File: tb/tb_cseq_top.sv
module tb_cseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din_we = 0, dout_re = 0, key_we = 0, key_sel = 0, cfg_we = 0, cfg_manual = 0;
    logic [1:0] din_idx = 0, dout_idx = 0, cfg_klen = 0;
    logic [2:0] key_idx = 0;
    logic [31:0] din_word = 0, key_word = 0, dout_word;
    logic cmd_start = 0, cmd_clr_in = 0, cmd_clr_out = 0, cmd_reseed = 0;
    logic core_start, core_done, reseed_req, idle, stall, in_ready, out_valid, out_lost, upd_err, fatal;
    logic [127:0] core_block, core_result;
    logic [255:0] core_key;

    int n_checks = 0, n_fail = 0, n_start = 0, n_reseed = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cseq_top dut (.*);

    // Fixed-latency stand-in core: result = block ^ key low half ^ key high half.
    int cnt = 0;
    logic [127:0] acc = '0;
    logic done_r = 0;
    logic [127:0] res_r = '0;
    assign core_done = done_r;
    assign core_result = res_r;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; done_r <= 0;
        end else begin
            done_r <= 0;
            if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin done_r <= 1; res_r <= acc; end
            end
            if (core_start) begin
                cnt <= LAT;
                acc <= core_block ^ core_key[127:0] ^ core_key[255:128];
            end
            if (core_start) n_start <= n_start + 1;
            if (reseed_req) n_reseed <= n_reseed + 1;
        end
    end

    function automatic logic [127:0] model(logic [127:0] blk, logic [255:0] s0, logic [255:0] s1, logic [1:0] kl);
        logic [255:0] k = s0 ^ s1;
        int lim = (kl == 0) ? 4 : (kl == 1) ? 6 : 8;
        for (int i = lim; i < 8; i++) k[i*32 +: 32] = '0;
        return blk ^ k[127:0] ^ k[255:128];
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_word(int i, logic [31:0] w);
        din_we = 1; din_idx = 2'(i); din_word = w;
        @(negedge clk); din_we = 0;
    endtask

    task automatic put_block(logic [127:0] b);
        for (int i = 0; i < 4; i++) put_word(i, b[i*32 +: 32]);
    endtask

    task automatic set_keys(logic [255:0] s0, logic [255:0] s1);
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) begin
                key_we = 1; key_sel = s[0]; key_idx = 3'(i);
                key_word = s ? s1[i*32 +: 32] : s0[i*32 +: 32];
                @(negedge clk); key_we = 0;
            end
    endtask

    task automatic set_cfg(logic man, logic [1:0] kl);
        cfg_we = 1; cfg_manual = man; cfg_klen = kl;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1; @(negedge clk); sig = 0;
    endtask

    task automatic rd_word(int i, output logic [31:0] w);
        dout_re = 1; dout_idx = 2'(i); #1 w = dout_word;
        @(negedge clk); dout_re = 0;
    endtask

    task automatic rd_block(output logic [127:0] b);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            rd_word(i, w); b[i*32 +: 32] = w;
        end
    endtask

    task automatic peek_block(output logic [127:0] b);
        dout_re = 0;
        for (int i = 0; i < 4; i++) begin dout_idx = 2'(i); #1 b[i*32 +: 32] = dout_word; end
    endtask

    task automatic wait_valid();
        for (int t = 0; t < 40 && !out_valid; t++) @(negedge clk);
    endtask

    task automatic idle_cycles(int n);
        for (int t = 0; t < n; t++) @(negedge clk);
    endtask

    localparam logic [255:0] S0 = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888,
                                   32'h9999_aaaa, 32'hbbbb_cccc, 32'hdddd_eeee, 32'h0f0f_f0f0};
    localparam logic [255:0] S1 = {32'hfeed_0001, 32'hcafe_0002, 32'hbeef_0003, 32'hface_0004,
                                   32'h0123_4567, 32'h89ab_cdef, 32'h1357_9bdf, 32'h2468_ace0};
    localparam logic [127:0] BA = 128'h0001_0203_0405_0607_0809_0a0b_0c0d_0e0f;
    localparam logic [127:0] BB = 128'hdead_beef_0bad_f00d_1234_5678_9abc_def0;

    task automatic t_reset();
        chk("R12 idle after reset", 128'(idle), 1);
        chk("R12 in_ready after reset", 128'(in_ready), 1);
        chk("R12 flags low after reset",
            128'({out_valid, stall, out_lost, upd_err, fatal, reseed_req}), 0);
    endtask

    task automatic t_auto_basic();
        logic [127:0] r; logic [31:0] w; int s0;
        set_cfg(0, 2); set_keys(S0, S1);
        s0 = n_start;
        put_block(BA);
        chk("R1 in_ready low with full block", 128'(in_ready), 0);
        put_word(0, 32'hffff_ffff);
        wait_valid();
        chk("R2 one auto launch", 128'(n_start - s0), 1);
        chk("R1 in_ready back after consume", 128'(in_ready), 1);
        rd_word(0, w); rd_word(0, w); rd_word(1, w); rd_word(2, w);
        chk("R4 valid held with word 3 unread", 128'(out_valid), 1);
        peek_block(r);
        chk("R1 R7 R4 result, full key, late write ignored", r, model(BA, S0, S1, 2));
        rd_word(3, w);
        chk("R4 valid falls after all words read", 128'(out_valid), 0);
    endtask

    task automatic t_klen(logic [1:0] kl);
        logic [127:0] r;
        set_cfg(0, kl);
        put_block(BB); wait_valid(); rd_block(r);
        chk($sformatf("R7 key length code %0d", kl), r, model(BB, S0, S1, kl));
    endtask

    task automatic t_manual();
        logic [127:0] r; int s0;
        set_cfg(0, 2);
        s0 = n_start;
        pulse(cmd_start); idle_cycles(LAT + 3);
        chk("R3 start ignored in auto mode", 128'(n_start - s0), 0);
        set_cfg(1, 2);
        put_word(0, BA[31:0]); put_word(1, BA[63:32]);
        pulse(cmd_start); idle_cycles(2);
        chk("R3 start ignored with partial block", 128'(n_start - s0), 0);
        put_word(2, BA[95:64]); put_word(3, BA[127:96]);
        idle_cycles(LAT + 3);
        chk("R3 no launch without start in manual", 128'({n_start - s0, out_valid}), 0);
        pulse(cmd_start); wait_valid();
        chk("R3 launch on start", 128'(n_start - s0), 1);
        rd_block(r);
        chk("R3 manual result", r, model(BA, S0, S1, 2));
    endtask

    task automatic t_stall(bit use_clear);
        logic [127:0] r;
        set_cfg(0, 2);
        put_block(BA); wait_valid();
        put_block(BB); idle_cycles(LAT + 4);
        chk("R5 stall raised", 128'(stall), 1);
        chk("R12 not idle while stalled", 128'(idle), 0);
        peek_block(r);
        chk("R5 old result kept during stall", r, model(BA, S0, S1, 2));
        if (use_clear) begin
            pulse(cmd_clr_out);
            chk("R10 output cleared", 128'({dout_word, out_valid}), 0);
        end else begin
            rd_block(r);
        end
        idle_cycles(2);
        chk(use_clear ? "R10 stall released by clear" : "R5 stall released by reads",
            128'({stall, out_valid, idle}), 128'(3'b011));
        peek_block(r);
        chk("R5 held result written", r, model(BB, S0, S1, 2));
        chk("R6 no loss in auto mode", 128'(out_lost), 0);
        rd_block(r);
    endtask

    task automatic t_lost();
        logic [127:0] r; logic [31:0] w;
        set_cfg(1, 2);
        put_block(BA); pulse(cmd_start); wait_valid();
        rd_word(0, w); rd_word(1, w);
        put_block(BB); pulse(cmd_start); idle_cycles(LAT + 3);
        chk("R6 out_lost set on overwrite", 128'(out_lost), 1);
        rd_block(r);
        chk("R6 newer result present", r, model(BB, S0, S1, 2));
        put_block(BA); pulse(cmd_start); wait_valid(); rd_block(r);
        chk("R6 out_lost stays set", 128'(out_lost), 1);
        pulse(cmd_clr_in);
        chk("R9 clear-input drops out_lost", 128'(out_lost), 0);
    endtask

    task automatic t_upd();
        logic [127:0] r;
        set_cfg(0, 2); set_keys(S0, S1);
        put_block(BA); idle_cycles(1);
        cfg_we = 1; cfg_manual = 1; cfg_klen = 0; @(negedge clk); cfg_we = 0;
        key_we = 1; key_sel = 0; key_idx = 0; key_word = 32'h0; @(negedge clk); key_we = 0;
        chk("R8 upd_err on busy write", 128'(upd_err), 1);
        wait_valid(); rd_block(r);
        chk("R8 busy key and config writes ignored", r, model(BA, S0, S1, 2));
        put_block(BB); wait_valid(); rd_block(r);
        chk("R8 mode still automatic", r, model(BB, S0, S1, 2));
        chk("R8 upd_err still set", 128'(upd_err), 1);
        pulse(cmd_clr_in);
        chk("R9 clear-input drops upd_err", 128'(upd_err), 0);
    endtask

    task automatic t_clear_in();
        logic [127:0] r; int s0;
        set_cfg(0, 2); set_keys(S0, S1);
        s0 = n_start;
        put_word(0, 32'h1); put_word(1, 32'h2); put_word(2, 32'h3);
        pulse(cmd_clr_in);
        put_word(3, BB[127:96]); idle_cycles(LAT + 2);
        chk("R9 partial block discarded", 128'({n_start - s0, in_ready}), 1);
        put_word(0, BB[31:0]); put_word(1, BB[63:32]); put_word(2, BB[95:64]);
        wait_valid(); rd_block(r);
        chk("R9 key shares zeroed", r, BB);
    endtask

    task automatic t_reseed();
        int r0 = n_reseed;
        pulse(cmd_reseed); idle_cycles(2);
        chk("R11 reseed pulse when idle", 128'(n_reseed - r0), 1);
        set_cfg(0, 2);
        put_block(BA); idle_cycles(1);
        pulse(cmd_reseed);
        chk("R11 reseed held while busy", 128'(n_reseed - r0), 1);
        wait_valid(); idle_cycles(2);
        chk("R11 deferred reseed issued once", 128'(n_reseed - r0), 2);
        pulse(cmd_clr_out);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_auto_basic();
        t_klen(0); t_klen(1); t_klen(3);
        t_manual();
        t_stall(0);
        t_stall(1);
        t_lost();
        t_upd();
        t_clear_in();
        t_reseed();
        chk("R13 fatal stays low", 128'(fatal), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule